// File: doc/BRIEF.md
# Byte-Port Unsigned Hardware Divider

This block is a divide unit that sits on an 8-bit register bus. It has two byte-wide ports, A and B, and each port is reached through the same write strobe, read strobe and port select. Software loads the dividend into port A one byte at a time, lowest byte first. It then loads the 16-bit divisor into port B, also lowest byte first. The second divisor byte launches the operation. A busy flag rises on the next clock and stays high for a fixed budget of machine cycles, whether or not the arithmetic finishes sooner.

When busy drops, the quotient can be read from port A and the remainder from port B, highest byte first. Each read strobe moves that port's byte pointer to the next byte. Loading only two dividend bytes gives a 16/16 divide, because the first byte of every load sequence clears the upper dividend bytes. A zero divisor raises an error flag. In that case the quotient comes back as all ones and the remainder is the low half of the dividend.

A machine cycle is `CLKS_PER_MC` clocks. The busy window is `BUSY_MC` machine cycles. A restoring shift-subtract engine retires `BITS_PER_MC` quotient bits at the end of each machine cycle.

Top module: `mdiv_unit`

## Requirements
- R1: The dividend is loaded by four writes to port A (`port_sel`=0), lowest byte first: the k-th write (k=0..3) fills bits [8k+7:8k].
- R2: If only two port-A writes precede the divisor, the dividend's upper 16 bits are zero, even when an earlier operation used them.
- R3: The divisor is loaded through port B (`port_sel`=1), low byte first. The first B write leaves `busy` low. The second B write starts the division, and `busy` is high on the next cycle.
- R4: `busy` stays high for exactly `BUSY_MC`×`CLKS_PER_MC` clock cycles (36 with the defaults) after the start edge, then falls.
- R5: Successive reads of port A return quotient bits [31:24], [23:16], [15:8], [7:0]. The next read wraps back to bits [31:24].
- R6: Successive reads of port B return remainder bits [15:8], then [7:0]. The next read wraps back to [15:8].
- R7: With a non-zero divisor the results are the unsigned quotient and remainder of dividend ÷ divisor.
- R8: A zero divisor sets `div_err`, gives quotient 0xFFFFFFFF and gives the dividend's low 16 bits as the remainder. The next operation with a non-zero divisor clears `div_err`.
- R9: Writes to either port while `busy` is high are ignored. They change neither the operands, nor the load position, nor the result.
- R10: Reads while `busy` is high do not advance the read pointers.
- R11: After reset, `busy` and `div_err` are low and a port-A read returns 0x00.
- R12: A new operation resets both read pointers, so its first read of each port returns the most significant byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the selected port |
| rd_en | input | 1 | Read strobe; moves the selected port's read pointer forward |
| port_sel | input | 1 | 0 selects port A (dividend/quotient), 1 selects port B (divisor/remainder) |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Byte at the selected port's current read position |
| busy | output | 1 | High while a division is running |
| div_err | output | 1 | High if the last operation had a zero divisor |

## Verification
Most internal faults here show up as a wrong byte. A load pointer that slips puts dividend bytes at the wrong weight. The bench sees this at the first quotient read, once the 36-cycle window has closed. A wrong machine-cycle or step count shows up as a busy edge one or more clocks off the expected cycle, or as a quotient missing its low bits. A read pointer that moves during busy, or that is not cleared at start, gives a low-order byte where the top byte belongs on the very first read. A zero-divide path with a wrong override gives a bad remainder. The bench checks that remainder, along with the error flag, right after busy falls.

// File: rtl/mdiv_pkg.sv
package mdiv_pkg;
    localparam int BYTE_W    = 8;
    localparam int DVD_W     = 32;
    localparam int DVS_W     = 16;
    localparam int DVD_BYTES = DVD_W / BYTE_W;
    localparam int DVS_BYTES = DVS_W / BYTE_W;
    localparam logic SEL_A   = 1'b0;
    localparam logic SEL_B   = 1'b1;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [DVD_W-1:0]  dvd_t;
    typedef logic [DVS_W-1:0]  dvs_t;

    typedef enum logic {ST_IDLE, ST_RUN} eng_state_e;

    // partial remainder and dividend/quotient shift register
    typedef struct packed {
        dvs_t rem;
        dvd_t quo;
    } work_t;

    // one restoring shift-subtract step
    function automatic work_t div_bit(work_t w, dvs_t d);
        logic [DVS_W:0] trial;
        work_t o;
        trial = {w.rem, w.quo[DVD_W-1]};
        o.quo = {w.quo[DVD_W-2:0], 1'b0};
        if (trial >= {1'b0, d}) begin
            trial    = trial - {1'b0, d};
            o.quo[0] = 1'b1;
        end
        o.rem = trial[DVS_W-1:0];
        return o;
    endfunction
endpackage

// File: rtl/mdiv_loader.sv
module mdiv_loader
    import mdiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic  port_sel,
    input  byte_t wr_data,
    input  logic  busy,
    output logic  start,
    output dvd_t  dividend,
    output dvs_t  divisor
);
    localparam int AP_W = $clog2(DVD_BYTES);
    localparam int BP_W = (DVS_BYTES > 1) ? $clog2(DVS_BYTES) : 1;
    localparam int LO_W = DVS_W - BYTE_W;

    logic [AP_W-1:0] a_ptr;
    logic [BP_W-1:0] b_ptr;
    dvd_t            dvd_q;
    logic [LO_W-1:0] dvs_lo_q;
    logic            wr_a, wr_b;

    assign wr_a     = wr_en && !busy && (port_sel == SEL_A);
    assign wr_b     = wr_en && !busy && (port_sel == SEL_B);
    assign start    = wr_b && (b_ptr == BP_W'(DVS_BYTES-1));
    assign dividend = dvd_q;
    assign divisor  = {wr_data, dvs_lo_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            a_ptr    <= '0;
            b_ptr    <= '0;
            dvd_q    <= '0;
            dvs_lo_q <= '0;
        end else if (start) begin
            a_ptr <= '0;
            b_ptr <= '0;
        end else begin
            if (wr_a) begin
                if (a_ptr == '0) begin
                    dvd_q <= dvd_t'(wr_data);   // fresh sequence: upper bytes cleared
                end else begin
                    for (int k = 1; k < DVD_BYTES; k++)
                        if (a_ptr == AP_W'(k)) dvd_q[k*BYTE_W +: BYTE_W] <= wr_data;
                end
                a_ptr <= a_ptr + 1'b1;
            end
            if (wr_b) begin
                for (int k = 0; k < DVS_BYTES-1; k++)
                    if (b_ptr == BP_W'(k)) dvs_lo_q[k*BYTE_W +: BYTE_W] <= wr_data;
                b_ptr <= b_ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mdiv_engine.sv
module mdiv_engine
    import mdiv_pkg::*;
#(
    parameter int CLKS_PER_MC = 4,
    parameter int BUSY_MC     = 9,
    parameter int BITS_PER_MC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  dvd_t dividend,
    input  dvs_t divisor,
    output logic busy,
    output dvd_t quo,
    output dvs_t rem,
    output logic err
);
    localparam int STEPS = DVD_W / BITS_PER_MC;
    localparam int CK_W  = (CLKS_PER_MC > 1) ? $clog2(CLKS_PER_MC) : 1;
    localparam int MC_W  = $clog2(BUSY_MC + 1);

    if (STEPS > BUSY_MC || (DVD_W % BITS_PER_MC) != 0) begin : g_bad_cfg
        $error("mdiv_engine: step count does not fit the busy window");
    end

    eng_state_e      state;
    work_t           w_q, w_next;
    dvs_t            d_q, dvd_lo_q;
    logic            err_q;
    logic [CK_W-1:0] clk_cnt;
    logic [MC_W-1:0] mc_cnt;
    logic            mc_end;

    assign mc_end = (clk_cnt == CK_W'(CLKS_PER_MC-1));

    always_comb begin
        w_next = w_q;
        for (int k = 0; k < BITS_PER_MC; k++)
            w_next = div_bit(w_next, d_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            w_q      <= '0;
            d_q      <= '0;
            dvd_lo_q <= '0;
            err_q    <= 1'b0;
            clk_cnt  <= '0;
            mc_cnt   <= '0;
        end else if (state == ST_IDLE) begin
            if (start) begin
                state    <= ST_RUN;
                w_q.rem  <= '0;
                w_q.quo  <= dividend;
                d_q      <= divisor;
                dvd_lo_q <= dividend[DVS_W-1:0];
                err_q    <= (divisor == '0);
                clk_cnt  <= '0;
                mc_cnt   <= '0;
            end
        end else if (mc_end) begin
            clk_cnt <= '0;
            if (mc_cnt < MC_W'(STEPS)) w_q <= w_next;
            if (mc_cnt == MC_W'(BUSY_MC-1)) state  <= ST_IDLE;
            else                            mc_cnt <= mc_cnt + 1'b1;
        end else begin
            clk_cnt <= clk_cnt + 1'b1;
        end
    end

    assign busy = (state == ST_RUN);
    assign quo  = w_q.quo;
    assign rem  = err_q ? dvd_lo_q : w_q.rem;
    assign err  = err_q;
endmodule

// File: rtl/mdiv_reader.sv
module mdiv_reader
    import mdiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_en,
    input  logic  port_sel,
    input  logic  busy,
    input  logic  start,
    input  dvd_t  quo,
    input  dvs_t  rem,
    output byte_t rd_data
);
    localparam int AP_W = $clog2(DVD_BYTES);
    localparam int BP_W = (DVS_BYTES > 1) ? $clog2(DVS_BYTES) : 1;

    logic [AP_W-1:0] a_rptr;
    logic [BP_W-1:0] b_rptr;
    logic            rd_ok;

    assign rd_ok = rd_en && !busy;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            a_rptr <= '0;
            b_rptr <= '0;
        end else if (rd_ok) begin
            if (port_sel == SEL_A) a_rptr <= a_rptr + 1'b1;
            else                   b_rptr <= b_rptr + 1'b1;
        end
    end

    // pointer 0 selects the most significant byte
    always_comb begin
        rd_data = '0;
        if (port_sel == SEL_A) begin
            for (int k = 0; k < DVD_BYTES; k++)
                if (a_rptr == AP_W'(k)) rd_data = quo[(DVD_BYTES-1-k)*BYTE_W +: BYTE_W];
        end else begin
            for (int k = 0; k < DVS_BYTES; k++)
                if (b_rptr == BP_W'(k)) rd_data = rem[(DVS_BYTES-1-k)*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/mdiv_unit.sv
module mdiv_unit
    import mdiv_pkg::*;
#(
    parameter int CLKS_PER_MC = 4,
    parameter int BUSY_MC     = 9,
    parameter int BITS_PER_MC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       port_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       busy,
    output logic       div_err
);
    logic start_w;
    dvd_t dvd_w, quo_w;
    dvs_t dvs_w, rem_w;

    mdiv_loader u_load (
        .clk(clk), .rst(rst), .wr_en(wr_en), .port_sel(port_sel),
        .wr_data(wr_data), .busy(busy), .start(start_w),
        .dividend(dvd_w), .divisor(dvs_w)
    );

    mdiv_engine #(
        .CLKS_PER_MC(CLKS_PER_MC), .BUSY_MC(BUSY_MC), .BITS_PER_MC(BITS_PER_MC)
    ) u_eng (
        .clk(clk), .rst(rst), .start(start_w), .dividend(dvd_w), .divisor(dvs_w),
        .busy(busy), .quo(quo_w), .rem(rem_w), .err(div_err)
    );

    mdiv_reader u_read (
        .clk(clk), .rst(rst), .rd_en(rd_en), .port_sel(port_sel), .busy(busy),
        .start(start_w), .quo(quo_w), .rem(rem_w), .rd_data(rd_data)
    );
endmodule

// File: rtl/mdiv_chk.sv
module mdiv_chk #(
    parameter int BUSY_CLKS = 36
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        err,
    input logic [31:0] quo
);
    localparam int CW = $clog2(BUSY_CLKS + 1) + 1;
    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy) busy_cnt <= '0;
        else              busy_cnt <= busy_cnt + 1'b1;
    end

    p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    p_busy_max_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_cnt < CW'(BUSY_CLKS)));

    p_busy_len_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(busy_cnt) == CW'(BUSY_CLKS-1)));

    p_no_start_busy_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start);

    p_err_ones_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && err) |-> (quo == 32'hFFFF_FFFF));

    p_idle_reset_r11: assert property (@(posedge clk)
        rst |=> (!busy && !err));
endmodule

bind mdiv_unit mdiv_chk #(.BUSY_CLKS(CLKS_PER_MC*BUSY_MC)) chk_i (
    .clk(clk), .rst(rst), .start(start_w), .busy(busy), .err(div_err), .quo(quo_w)
);

// File: tb/mdiv_unit_tb_top.sv
module mdiv_unit_tb_top;
    localparam int NV = 8;
    localparam logic [31:0] TV_DVD [NV] = '{
        32'h1234_5678, 32'h0000_BEEF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
        32'h89AB_CDEF, 32'h0000_0005, 32'hDEAD_BEEF, 32'h0000_FFFF };
    localparam logic [15:0] TV_DVS [NV] = '{
        16'h1234, 16'h0011, 16'h0001, 16'hFFFF,
        16'h0000, 16'h0007, 16'h8000, 16'h0000 };
    localparam int TV_NB [NV] = '{4, 2, 4, 4, 4, 4, 4, 2};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, port_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       busy, div_err;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    mdiv_unit dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .port_sel(port_sel),
        .wr_data(wr_data), .rd_data(rd_data), .busy(busy), .div_err(div_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    task automatic wr_byte(input logic sel, input logic [7:0] d);
        @(negedge clk);
        port_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_byte(input logic sel, output logic [7:0] v);
        @(negedge clk);
        port_sel = sel; rd_en = 1'b0;
        #1 v = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic load(input logic [31:0] dvd, input logic [15:0] dvs, input int nb);
        for (int i = 0; i < nb; i++) wr_byte(1'b0, dvd[8*i +: 8]);
        wr_byte(1'b1, dvs[7:0]);
        chk("R3 no start after first divisor byte", {31'h0, busy}, 32'h0);
        wr_byte(1'b1, dvs[15:8]);
        chk("R3 busy after second divisor byte", {31'h0, busy}, 32'h1);
    endtask

    task automatic read_all(output logic [31:0] q, output logic [15:0] r);
        logic [7:0] b;
        q = '0; r = '0;
        for (int i = 0; i < 4; i++) begin rd_byte(1'b0, b); q = {q[23:0], b}; end
        for (int i = 0; i < 2; i++) begin rd_byte(1'b1, b); r = {r[7:0], b}; end
    endtask

    task automatic expect_div(input logic [31:0] d, input logic [15:0] s,
                              output logic [31:0] q, output logic [15:0] r, output logic e);
        if (s == 16'h0) begin
            q = 32'hFFFF_FFFF; r = d[15:0]; e = 1'b1;
        end else begin
            q = d / {16'h0, s};
            r = 16'(d % {16'h0, s});
            e = 1'b0;
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual hung expected finish");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] q, eq, dd;
        logic [15:0] r, er;
        logic        ee;
        logic [7:0]  b;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R11 busy after reset", {31'h0, busy}, 32'h0);
        chk("R11 div_err after reset", {31'h0, div_err}, 32'h0);
        chk("R11 port A read after reset", {24'h0, rd_data}, 32'h0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            dd = (TV_NB[v] == 2) ? {16'h0, TV_DVD[v][15:0]} : TV_DVD[v];
            expect_div(dd, TV_DVS[v], eq, er, ee);
            load(TV_DVD[v], TV_DVS[v], TV_NB[v]);
            repeat (34) @(negedge clk);
            chk("R4 busy held", {31'h0, busy}, 32'h1);
            @(negedge clk);
            chk("R4 busy last cycle", {31'h0, busy}, 32'h1);
            @(negedge clk);
            chk("R4 busy cleared", {31'h0, busy}, 32'h0);
            chk("R8 error flag", {31'h0, div_err}, {31'h0, ee});
            read_all(q, r);
            if (TV_NB[v] == 2) begin
                chk("R2 R5 R7 R12 quotient 16/16", q, eq);
                chk("R2 R6 R7 remainder 16/16", {16'h0, r}, {16'h0, er});
            end else begin
                chk("R1 R5 R7 R8 R12 quotient", q, eq);
                chk("R1 R6 R7 R8 remainder", {16'h0, r}, {16'h0, er});
            end
        end

        // R5/R6 wrap after a full read sequence
        rd_byte(1'b0, b);
        chk("R5 port A wraps to top byte", {24'h0, b}, {24'h0, eq[31:24]});
        rd_byte(1'b1, b);
        chk("R6 port B wraps to top byte", {24'h0, b}, {24'h0, er[15:8]});

        // R9 / R10: accesses during busy
        expect_div(32'h00C0_FFEE, 16'h0100, eq, er, ee);
        load(32'h00C0_FFEE, 16'h0100, 4);
        wr_byte(1'b0, 8'h55);
        wr_byte(1'b1, 8'h00);
        wr_byte(1'b1, 8'h00);
        rd_byte(1'b0, b);
        rd_byte(1'b1, b);
        wait_idle();
        chk("R9 error flag untouched by ignored writes", {31'h0, div_err}, 32'h0);
        read_all(q, r);
        chk("R9 R10 quotient after busy accesses", q, eq);
        chk("R9 R10 remainder after busy accesses", {16'h0, r}, {16'h0, er});

        // ignored write must not have moved the load position
        expect_div(32'h0000_0064, 16'h000A, eq, er, ee);
        load(32'h0000_0064, 16'h000A, 2);
        wait_idle();
        read_all(q, r);
        chk("R9 load position kept after ignored write", q, eq);
        chk("R9 remainder after ignored write", {16'h0, r}, {16'h0, er});

        // R12: partial read, then a new operation restarts at the top byte
        rd_byte(1'b0, b);
        rd_byte(1'b1, b);
        expect_div(32'hA1B2_C3D4, 16'h0003, eq, er, ee);
        load(32'hA1B2_C3D4, 16'h0003, 4);
        wait_idle();
        read_all(q, r);
        chk("R12 quotient after partial read", q, eq);
        chk("R12 remainder after partial read", {16'h0, r}, {16'h0, er});

        done = 1'b1;
        report();
        $finish;
    end
endmodule